// File: doc/BRIEF.md
# Periodic Loaded-Battery Test Scheduler

This block decides when a backup cell is put under a test load and keeps the active-low warning that reports a weak cell. Once main power is good and the power-up recovery time has expired, the block runs a test straight away. A test holds the load-enable high for a fixed number of cycles. The block reads a digital "cell below trip level" comparator on the final cycle of that pulse. A low reading drives the warning low; a good reading releases it.

Between tests the block waits out one of two idle gaps. The long gap is used while the warning is released. The short gap is used while the warning is held, so that removal and replacement of the cell shows up quickly. When power fails, scheduling stops at once. A pulse that is cut short gives no verdict, and the warning keeps its value through the outage. The next recovery pulse always starts a fresh test, even when the warning is held. The analog load and the comparator sit outside the block.

The controller has three states. OFF means no power, or power that has not yet recovered. PULSE means the test load is on. GAP means the block is idle between tests. The transitions are:
- START: OFF to PULSE when recovery is signalled with power good.
- VERDICT: PULSE to GAP on the last pulse cycle.
- RETEST: GAP to PULSE when the gap timer expires.
- ABORT: PULSE or GAP to OFF when power is lost.

Top module: `batt_test_sched`

## Requirements
- R1: While reset is asserted, and right after it, `load_en` is 0, `warn_n` is 1 and the controller is in OFF.
- R2: A `recov_done` pulse sampled with `pwr_good` high makes `load_en` high from the next cycle. A `recov_done` pulse sampled with `pwr_good` low is ignored.
- R3: Each test holds `load_en` high for exactly `PULSE_CYC` consecutive cycles.
- R4: `below_trip` is sampled only on the last cycle of a pulse, and its value on earlier pulse cycles has no effect. `warn_n` takes its new value on the same clock edge at which `load_en` falls.
- R5: If `below_trip` is 1 on that last cycle, `warn_n` becomes 0 (warning active).
- R6: After a passing test, `load_en` stays low for exactly `NORM_GAP` cycles, and then the next pulse starts.
- R7: After a failing test, `load_en` stays low for exactly `WARN_GAP` cycles, and then the next pulse starts. This repeats for as long as the warning is held.
- R8: The warning is sticky. It clears (`warn_n` back to 1) only when a later test reads `below_trip` as 0, and the long gap then applies again.
- R9: When `pwr_good` goes low, `load_en` is 0 from the next cycle. A pulse in progress gives no verdict, and `warn_n` keeps its value through the outage.
- R10: After power returns, the recovery pulse starts a test even if `warn_n` was 0 at power-down.
- R11: While in OFF, no test starts without a recovery pulse, even if `pwr_good` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Main supply within tolerance |
| recov_done | input | 1 | One-cycle pulse: power-up recovery time expired |
| below_trip | input | 1 | Comparator: loaded cell below trip level |
| load_en | output | 1 | Enables the test load |
| warn_n | output | 1 | Battery warning, active low |

## Verification
The bench builds the block with `PULSE_CYC` = 4, `NORM_GAP` = 40 and `WARN_GAP` = 10. With these values, many pass and fail cycles, and a switch between the two gap lengths, fit in a few hundred clock cycles. Because both gap lengths are small, the bench can measure them exactly, cycle by cycle, rather than only noting that a test happened. The short pulse makes it easy to drive the comparator against the expected verdict on every cycle except the last. It also makes it easy to drop power partway through a pulse.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } bts_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/bts_timer.sv
module bts_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               count <= '0;
        else if (load)            count <= load_val;
        else if (count != '0)     count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R6: an expired timer stays at zero until reloaded
    a_r6_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
    import bts_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned NORM_GAP  = 40,
    parameter int unsigned WARN_GAP  = 10,
    parameter int unsigned CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          recov_done,
    input  logic          below_trip,
    input  logic          tmr_zero,
    output logic          load_en,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          sample_stb
);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] NORM_LD  = CW'(NORM_GAP - 1);
    localparam logic [CW-1:0] WARN_LD  = CW'(WARN_GAP - 1);

    bts_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (pwr_good && recov_done) state_nx = ST_PULSE;  // START
            ST_PULSE: if (!pwr_good)              state_nx = ST_OFF;    // ABORT
                      else if (tmr_zero)          state_nx = ST_GAP;    // VERDICT
            ST_GAP:   if (!pwr_good)              state_nx = ST_OFF;    // ABORT
                      else if (tmr_zero)          state_nx = ST_PULSE;  // RETEST
            default:                              state_nx = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        load_en    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = PULSE_LD;
        sample_stb = 1'b0;
        unique case (state)
            ST_OFF: begin
                tmr_load = pwr_good && recov_done;
            end
            ST_PULSE: begin
                load_en = 1'b1;
                if (pwr_good && tmr_zero) begin
                    sample_stb = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = below_trip ? WARN_LD : NORM_LD;
                end
            end
            ST_GAP: begin
                tmr_load = pwr_good && tmr_zero;
            end
            default: ;
        endcase
    end

    // pulse age, used only by the checks below
    logic [CW-1:0] pulse_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pulse_age <= '0;
        else if (state == ST_PULSE) pulse_age <= pulse_age + 1'b1;
        else                        pulse_age <= '0;
    end

    // R3: a pulse never runs past its length
    a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (pulse_age < CW'(PULSE_CYC)));

    // R11: leaving OFF requires a recovery pulse with good power
    a_r11_start_needs_recov: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && $past(state) == ST_OFF) |-> $past(recov_done && pwr_good));

    initial begin
        a_r7_gap_order: assert (PULSE_CYC >= 1 && WARN_GAP >= 1 && WARN_GAP <= NORM_GAP);
    end

endmodule

// File: rtl/bts_flag.sv
module bts_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic below_trip,
    output logic warn_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warn_n <= 1'b1;
        else if (sample_stb) warn_n <= !below_trip;
    end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
    import bts_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 1000,
    parameter int unsigned NORM_GAP  = 86_399_000,
    parameter int unsigned WARN_GAP  = 4_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic recov_done,
    input  logic below_trip,
    output logic load_en,
    output logic warn_n
);
    localparam int unsigned MAXV = max3(PULSE_CYC, NORM_GAP, WARN_GAP);
    localparam int unsigned CW   = $clog2(MAXV + 1);

    logic          tmr_load, tmr_zero, sample_stb;
    logic [CW-1:0] tmr_val;

    bts_ctrl #(
        .PULSE_CYC(PULSE_CYC), .NORM_GAP(NORM_GAP),
        .WARN_GAP(WARN_GAP), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .recov_done(recov_done), .below_trip(below_trip),
        .tmr_zero(tmr_zero), .load_en(load_en), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .sample_stb(sample_stb)
    );

    bts_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    bts_flag u_flag (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .below_trip(below_trip), .warn_n(warn_n)
    );

    // R9: losing power removes the load on the next cycle
    a_r9_power_loss_stops_load: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !load_en);

    // R4: the warning only moves as a pulse ends under good power
    a_r4_warn_moves_at_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_n) |-> ($past(load_en) && $past(pwr_good) && !load_en));

endmodule

// File: tb/tb_batt_test_sched.sv
module tb_batt_test_sched;
    localparam int unsigned PC = 4;
    localparam int unsigned NG = 40;
    localparam int unsigned WG = 10;

    typedef struct packed {
        logic        bad;
        logic        exp_warn_n;
        logic [31:0] exp_gap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, NG},
        '{1'b1, 1'b0, WG},
        '{1'b1, 1'b0, WG},
        '{1'b0, 1'b1, NG},
        '{1'b1, 1'b0, WG},
        '{1'b0, 1'b1, NG}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic recov_done = 1'b0;
    logic below_trip = 1'b0;
    logic load_en, warn_n;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    batt_test_sched #(.PULSE_CYC(PC), .NORM_GAP(NG), .WARN_GAP(WG)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .recov_done(recov_done), .below_trip(below_trip),
        .load_en(load_en), .warn_n(warn_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_pulse(input logic bad, output int width);
        width = 0;
        while (load_en && width < 1000) begin
            below_trip = bad;
            width++;
            @(negedge clk);
        end
        below_trip = 1'b0;
    endtask

    task automatic count_gap(output int g);
        g = 0;
        while (!load_en && g < 1000) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic recover;
        recov_done = 1'b1;
        @(negedge clk);
        recov_done = 1'b0;
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        report();
    end

    initial begin
        int w, g, seen;
        repeat (3) @(negedge clk);
        check("R1 load_en in reset", load_en, 0);
        check("R1 warn_n in reset", warn_n, 1);
        rst_n = 1'b1;
        pwr_good = 1'b1;
        seen = 0;
        repeat (20) begin @(negedge clk); if (load_en) seen++; end
        check("R11 no test before recovery", seen, 0);
        recover();
        check("R2 pulse starts after recovery", load_en, 1);

        // table walk
        for (int i = 0; i < 6; i++) begin
            run_pulse(VECS[i].bad, w);
            check("R3 pulse width", w, PC);
            check(VECS[i].bad ? "R5 warn after fail" : "R8 warn after pass",
                  warn_n, VECS[i].exp_warn_n);
            count_gap(g);
            check(VECS[i].bad ? "R7 warning gap" : "R6 normal gap",
                  g, int'(VECS[i].exp_gap));
        end

        // R4: bad on early cycles, good on last -> stays clear
        for (int k = 0; k < int'(PC); k++) begin
            below_trip = (k < int'(PC) - 1);
            @(negedge clk);
        end
        below_trip = 1'b0;
        check("R4 early cycles ignored (pass)", warn_n, 1);
        check("R4 load_en falls with verdict", load_en, 0);
        count_gap(g);
        check("R6 normal gap after R4", g, NG);
        // R4: good on early cycles, bad on last -> warning
        for (int k = 0; k < int'(PC); k++) begin
            below_trip = (k == int'(PC) - 1);
            @(negedge clk);
        end
        below_trip = 1'b0;
        check("R4 last cycle decides (fail)", warn_n, 0);
        count_gap(g);
        check("R7 warning gap after R4", g, WG);

        // R9: power loss mid-pulse, good cell shown, no verdict
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        check("R9 load off after power loss", load_en, 0);
        seen = 0;
        repeat (30) begin @(negedge clk); if (load_en) seen++; end
        recover();
        repeat (30) begin @(negedge clk); if (load_en) seen++; end
        check("R9 no test during outage", seen, 0);
        check("R2 recovery ignored without power", load_en, 0);
        check("R9 warn kept through abort", warn_n, 0);

        // R10: power returns, retest despite held warning
        pwr_good = 1'b1;
        seen = 0;
        repeat (15) begin @(negedge clk); if (load_en) seen++; end
        check("R11 no test before recovery on return", seen, 0);
        recover();
        check("R10 retest after power-up", load_en, 1);
        run_pulse(1'b0, w);
        check("R3 width on retest", w, PC);
        check("R8 retest clears warning", warn_n, 1);
        count_gap(g);
        check("R8 normal gap resumes", g, NG);

        // R1: reset mid-pulse
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 load_en after reset", load_en, 0);
        check("R1 warn_n after reset", warn_n, 1);
        rst_n = 1'b1;
        seen = 0;
        repeat (10) begin @(negedge clk); if (load_en) seen++; end
        check("R1 idle in OFF after reset", seen, 0);
        report();
    end
endmodule